// File: doc/BRIEF.md
# SPI Slave Memory Bridge

This block lets an external SPI master read and write an on-chip byte-addressed memory or register space. The SPI pins are not used as clocks. A fast system clock samples the serial clock, the chip select and the input data through two-flop synchronizers. Serial-clock edges are found by comparing successive synchronized samples. The system clock must run at least five times faster than the serial clock.

Each transaction starts when chip select falls and is framed as follows:

- one command byte;
- a multi-byte address, 24 bits by default;
- a burst of data bytes.

Each completed write data byte becomes one single-beat write request on the internal bus. Reads prefetch one byte ahead, and a dummy byte gives the first fetch time to return. The address advances by one after every data byte, so a burst touches consecutive locations. Raising chip select ends the transaction at once.

Top module: `spi_mem_bridge`

## Requirements
- R1: The bridge works in SPI mode 0 (serial clock idles low) and in mode 3 (serial clock idles high). The idle level at the moment chip select falls selects the mode.
- R2: Input data is captured on serial-clock rising edges, most significant bit first. Output data changes only on falling edges. The first bit of each output byte is valid before the byte's first rising edge.
- R3: The first byte after chip select falls is a command: 0x02 means write and 0x03 means read. Any other value starts no memory request before chip select rises, and the output enable stays 0.
- R4: The address follows the command as ADDR_BYTES bytes (3 by default), most significant byte first. Addresses at and above 0x840000 are reachable.
- R5: In a write, each completed data byte issues exactly one write request. The request carries that byte and the current address.
- R6: After every data byte, the address advances by exactly one, and carries propagate into the higher address bytes.
- R7: In a read, one dummy byte follows the address. The data bytes after it return the memory contents at the start address, then at start+1, start+2 and so on.
- R8: A request (mem_req high) keeps its address, direction and write data unchanged until the cycle in which mem_ack is seen.
- R9: When chip select rises, the transaction ends. A partially received byte is discarded and issues no request. The next transaction starts again with a command byte.
- R10: spi_miso_oe is 1 only while chip select is low and the bridge is in the read data phase. While spi_miso_oe is 0, spi_miso is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 5x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (0 when not enabled) |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 8*ADDR_BYTES | Byte address of the request |
| mem_wdata | output | 8 | Write data byte |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |

## Verification
The bench aims at the following corner cases:

- **Mode 3 edge order.** A bridge that shifted output on the falling edge right after a byte load would lose the most significant bit of every read byte in mode 3.
- **Address carry.** A burst that crosses a 256-byte boundary exposes an incrementer that drops the carry into the upper address byte.
- **Aborted transfers.** A transfer cut off mid-command or mid-data catches a bridge that commits partial bytes or keeps a stale bit count.
- **Invalid commands and write bursts.** An unknown command followed by a valid-looking write pattern, and a write burst against a slow acknowledge, show whether requests appear where none belong. They also show whether request fields drift before the acknowledge.

// File: rtl/spi_mem_bridge_pkg.sv
package spi_mem_bridge_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } bridge_state_e;

    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_n_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] cs_n;
        logic [STAGES-1:0] mosi;
        logic              sck_last;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], sck_i};
        d.cs_n     = {q.cs_n[STAGES-2:0], cs_n_i};
        d.mosi     = {q.mosi[STAGES-2:0], mosi_i};
        d.sck_last = q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck      <= '0;
            q.cs_n     <= '1;
            q.mosi     <= '0;
            q.sck_last <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = q.sck[STAGES-1] & ~q.sck_last;
    assign sck_fall = ~q.sck[STAGES-1] & q.sck_last;
    assign cs_n_o   = q.cs_n[STAGES-1];
    assign mosi_o   = q.mosi[STAGES-1];

endmodule

// File: rtl/spi_bridge_core.sv
module spi_bridge_core
    import spi_mem_bridge_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);

    localparam int ACNT_W = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        bridge_state_e     state;
        logic [2:0]        bit_cnt;
        logic [6:0]        rx_sh;
        logic [7:0]        tx_sh;
        logic [7:0]        rd_buf;
        logic [ACNT_W-1:0] abyte_cnt;
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic              we;
        logic [7:0]        wdata;
    } core_t;

    core_t d, q;
    logic [7:0] rx_byte;
    logic       byte_done;

    always_comb begin
        d         = q;
        rx_byte   = {q.rx_sh, mosi};
        byte_done = sck_rise && (q.bit_cnt == 3'd7);

        // completed bus beat: step the address, keep fetched data
        if (q.req && mem_ack) begin
            d.req  = 1'b0;
            d.addr = q.addr + ADDR_W'(1);
            if (!q.we) begin
                d.rd_buf = mem_rdata;
            end
        end

        if (cs_n) begin
            d.state     = ST_CMD;
            d.bit_cnt   = '0;
            d.abyte_cnt = '0;
            d.tx_sh     = '0;
        end else begin
            // no shift on the falling edge that follows a byte load
            if (sck_fall && (q.bit_cnt != 3'd0) && (q.state == ST_RDATA)) begin
                d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
            if (sck_rise) begin
                d.rx_sh   = rx_byte[6:0];
                d.bit_cnt = q.bit_cnt + 3'd1;
            end
            if (byte_done) begin
                unique case (q.state)
                    ST_CMD: begin
                        d.abyte_cnt = '0;
                        if (rx_byte == OP_WRITE) begin
                            d.state = ST_ADDR;
                            d.we    = 1'b1;
                        end else if (rx_byte == OP_READ) begin
                            d.state = ST_ADDR;
                            d.we    = 1'b0;
                        end else begin
                            d.state = ST_SKIP;
                        end
                    end
                    ST_ADDR: begin
                        d.addr      = (q.addr << 8) | ADDR_W'(rx_byte);
                        d.abyte_cnt = q.abyte_cnt + ACNT_W'(1);
                        if (q.abyte_cnt == ACNT_W'(ADDR_BYTES - 1)) begin
                            if (q.we) begin
                                d.state = ST_WDATA;
                            end else begin
                                d.state = ST_DUMMY;
                                d.req   = 1'b1;
                            end
                        end
                    end
                    ST_DUMMY, ST_RDATA: begin
                        d.tx_sh = q.rd_buf;
                        d.state = ST_RDATA;
                        d.req   = 1'b1;
                    end
                    ST_WDATA: begin
                        d.wdata = rx_byte;
                        d.req   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_CMD;
            q.bit_cnt   <= '0;
            q.rx_sh     <= '0;
            q.tx_sh     <= '0;
            q.rd_buf    <= '0;
            q.abyte_cnt <= '0;
            q.addr      <= '0;
            q.req       <= 1'b0;
            q.we        <= 1'b0;
            q.wdata     <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso_oe   = (q.state == ST_RDATA) && !cs_n;
    assign miso      = q.tx_sh[7] & miso_oe;
    assign mem_req   = q.req;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata
);

    logic sck_rise, sck_fall, cs_n_s, mosi_s;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_n_o   (cs_n_s),
        .mosi_o   (mosi_s)
    );

    spi_bridge_core #(.ADDR_BYTES(ADDR_BYTES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_n      (cs_n_s),
        .mosi      (mosi_s),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_sync_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              spi_miso,
    input logic              spi_miso_oe
);

    // R8: an unanswered request keeps all of its fields
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: an accepted beat moves the address on by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R10: output enable only while selected
    a_r10_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> !cs_sync_n);

    // R10: data line quiet while not enabled
    a_r10_quiet_miso: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    // R3 / R9: a new request only starts from a selected transaction
    a_r3_req_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !$past(cs_sync_n));

endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_sync_n   (cs_n_s),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_mem_bridge_test.sv
module spi_mem_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;   // serial half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spi_mem_bridge uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: read data is address low byte xor 0x5A
    int          ack_lat = 0;
    int          lat_cnt = 0;
    int          wr_n = 0;
    int          rd_n = 0;
    logic [23:0] wr_addr_log [0:31];
    logic [7:0]  wr_data_log [0:31];
    logic [23:0] rd_addr_log [0:31];

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= ack_lat) begin
                mem_ack   <= 1'b1;
                lat_cnt   <= 0;
                mem_rdata <= mem_addr[7:0] ^ 8'h5A;
                if (mem_we) begin
                    if (wr_n < 32) begin
                        wr_addr_log[wr_n] <= mem_addr;
                        wr_data_log[wr_n] <= mem_wdata;
                    end
                    wr_n <= wr_n + 1;
                end else begin
                    if (rd_n < 32) rd_addr_log[rd_n] <= mem_addr;
                    rd_n <= rd_n + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input bit m3, input logic [7:0] tx, input int nbits,
                            output logic [7:0] rxb);
        rxb = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (m3) spi_sck = 1'b0;
            spi_mosi = tx[i];
            wait_clk(HP);
            rxb[i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(HP);
            if (!m3) spi_sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input bit m3, input logic [7:0] tx, output logic [7:0] rxb);
        spi_bits(m3, tx, 8, rxb);
    endtask

    task automatic cs_begin(input bit m3);
        spi_sck = m3;
        wait_clk(HP);
        spi_cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_end();
        wait_clk(HP);
        spi_cs_n = 1'b1;
        wait_clk(4 * HP);
    endtask

    task automatic send_header(input bit m3, input logic [7:0] cmd, input logic [23:0] a);
        logic [7:0] junk;
        spi_byte(m3, cmd, junk);
        spi_byte(m3, a[23:16], junk);
        spi_byte(m3, a[15:8], junk);
        spi_byte(m3, a[7:0], junk);
    endtask

    task automatic t_reset();
        chk("R10 reset oe", 32'(spi_miso_oe), 32'd0);
        chk("R10 reset miso", 32'(spi_miso), 32'd0);
        chk("R8 reset req", 32'(mem_req), 32'd0);
    endtask

    // mode 0 write burst of three bytes to a high address
    task automatic t_write_mode0();
        logic [7:0] junk;
        logic [7:0] dat [3] = '{8'hA5, 8'h3C, 8'h7E};
        int base = wr_n;
        cs_begin(1'b0);
        send_header(1'b0, 8'h02, 24'h840010);
        for (int k = 0; k < 3; k++) spi_byte(1'b0, dat[k], junk);
        wait_clk(4);
        chk("R10 oe low in write", 32'(spi_miso_oe), 32'd0);
        cs_end();
        chk("R5 write count", 32'(wr_n - base), 32'd3);
        for (int k = 0; k < 3; k++) begin
            chk("R4 R6 write addr", 32'(wr_addr_log[base + k]), 32'h840010 + 32'(k));
            chk("R2 R5 write data", 32'(wr_data_log[base + k]), 32'(dat[k]));
        end
    endtask

    // mode 3 read burst: dummy byte, then three bytes
    task automatic t_read_mode3();
        logic [7:0] rxb;
        int base = rd_n;
        cs_begin(1'b1);
        send_header(1'b1, 8'h03, 24'h840020);
        chk("R10 oe low before dummy", 32'(spi_miso_oe), 32'd0);
        spi_byte(1'b1, 8'h00, rxb);
        wait_clk(2);
        chk("R10 oe high in read data", 32'(spi_miso_oe), 32'd1);
        for (int k = 0; k < 3; k++) begin
            spi_byte(1'b1, 8'h00, rxb);
            chk("R1 R2 R7 read data mode3", 32'(rxb), 32'((8'h20 + 8'(k)) ^ 8'h5A));
        end
        cs_end();
        chk("R10 oe low after cs", 32'(spi_miso_oe), 32'd0);
        chk("R4 R7 first read addr", 32'(rd_addr_log[base]), 32'h840020);
    endtask

    // mode 0 read crossing a 256-byte boundary
    task automatic t_read_carry();
        logic [7:0] rxb;
        logic [7:0] exp [3] = '{8'hA4, 8'hA5, 8'h5A};
        int base = rd_n;
        cs_begin(1'b0);
        send_header(1'b0, 8'h03, 24'h0000FE);
        spi_byte(1'b0, 8'h00, rxb);
        for (int k = 0; k < 3; k++) begin
            spi_byte(1'b0, 8'h00, rxb);
            chk("R1 R7 read data mode0", 32'(rxb), 32'(exp[k]));
        end
        cs_end();
        chk("R6 carry read addr", 32'(rd_addr_log[base + 2]), 32'h000100);
    endtask

    // mode 3 write with slow acknowledge across a carry
    task automatic t_write_slow();
        logic [7:0] junk;
        int base = wr_n;
        ack_lat = 5;
        cs_begin(1'b1);
        send_header(1'b1, 8'h02, 24'h8400FF);
        spi_byte(1'b1, 8'h11, junk);
        spi_byte(1'b1, 8'h22, junk);
        cs_end();
        ack_lat = 0;
        chk("R8 slow write count", 32'(wr_n - base), 32'd2);
        chk("R8 slow write data0", 32'(wr_data_log[base]), 32'h11);
        chk("R1 R6 slow write addr1", 32'(wr_addr_log[base + 1]), 32'h840100);
        chk("R8 slow write data1", 32'(wr_data_log[base + 1]), 32'h22);
    endtask

    // unknown command followed by a write-shaped pattern
    task automatic t_bad_cmd();
        logic [7:0] junk;
        int wb = wr_n;
        int rb = rd_n;
        cs_begin(1'b0);
        send_header(1'b0, 8'h5A, 24'h028400);
        spi_byte(1'b0, 8'h55, junk);
        chk("R3 oe low after bad cmd", 32'(spi_miso_oe), 32'd0);
        cs_end();
        chk("R3 no write after bad cmd", 32'(wr_n - wb), 32'd0);
        chk("R3 no read after bad cmd", 32'(rd_n - rb), 32'd0);
    endtask

    // aborted command byte, then a clean write
    task automatic t_abort_cmd();
        logic [7:0] junk;
        int base = wr_n;
        cs_begin(1'b0);
        spi_bits(1'b0, 8'h02, 5, junk);
        cs_end();
        cs_begin(1'b0);
        send_header(1'b0, 8'h02, 24'h840030);
        spi_byte(1'b0, 8'h99, junk);
        cs_end();
        chk("R9 write after abort count", 32'(wr_n - base), 32'd1);
        chk("R9 write after abort addr", 32'(wr_addr_log[base]), 32'h840030);
        chk("R9 write after abort data", 32'(wr_data_log[base]), 32'h99);
    endtask

    // aborted data byte: only the complete byte is written
    task automatic t_abort_data();
        logic [7:0] junk;
        int base = wr_n;
        cs_begin(1'b1);
        send_header(1'b1, 8'h02, 24'h840040);
        spi_byte(1'b1, 8'h12, junk);
        spi_bits(1'b1, 8'h34, 3, junk);
        cs_end();
        chk("R9 partial byte dropped", 32'(wr_n - base), 32'd1);
        chk("R5 R9 full byte kept", 32'(wr_data_log[base]), 32'h12);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_mode0();
        t_read_mode3();
        t_read_carry();
        t_write_slow();
        t_bad_cmd();
        t_abort_cmd();
        t_abort_data();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule